// File: doc/BRIEF.md
# CPU Bus Release Sequencer

This block lets an external bus master, such as a DMA engine or a video fetch unit, take a two-phase 6502-style CPU core off the shared bus. It never touches the core clock. It works only through two enable-style lines. The ready line (`rdy`) pauses the core. The bus-enable line (`be`) turns off the core's address, data and read/write drivers. The block watches a phase indication (`phi2`) from one fast system clock. It changes state only at the PHI2 edges it detects.

When a halt is requested, the block drops ready at a rising PHI2 edge. At a later falling edge, once the core is really stalled, it drops bus enable and raises `grant`. When the request goes away, the steps run in reverse order: bus enable returns at a falling edge, then ready returns at the next rising edge. A separate mode input chooses between two stall styles. In the older style, ready stalls only read cycles, so a write in flight completes. In the newer style, ready stalls reads and writes.

Top module: `bus_release_seq`

## Requirements
- R1: After reset, `rdy` is 1, `be` is 1, `grant` is 0 and every bit of `addr_oe`, `data_oe` and `rw_oe` is 1.
- R2: If `halt_req` is 1 at a detected rising edge of `phi2` while the core runs, `rdy` goes to 0 at that edge.
- R3: With `rdy_mode` = 0 (read-only stall) and `rdy` = 0, `stall` is 1 only when `cpu_rw` = 1 (read). A write cycle (`cpu_rw` = 0) is not stalled.
- R4: With `rdy_mode` = 1 (read and write stall) and `rdy` = 0, `stall` is 1 for both values of `cpu_rw`.
- R5: `be` falls only at a detected falling edge of `phi2`, and only when all of these hold at that edge: `rdy` was already 0, `halt_req` is 1 and `stall` is 1. A write in progress under `rdy_mode` = 0 therefore postpones the release to a later falling edge.
- R6: `grant` is 1 exactly while the bus is released. It is never 1 while `be` is 1.
- R7: When `halt_req` is 0 at a falling edge while the bus is released, `be` returns to 1 at that edge. `rdy` returns to 1 at the following rising edge.
- R8: If `halt_req` drops after `rdy` has fallen but before `be` has fallen, `be` stays 1, and `rdy` returns to 1 at the next rising edge.
- R9: `addr_oe`, `data_oe` and `rw_oe` are all ones while `be` is 1 and all zeros while `be` is 0.
- R10: `rdy` and `be` change only in the system clock cycle that follows a detected `phi2` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than PHI2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | PHI2 phase indication, sampled by `clk` |
| cpu_rw | input | 1 | Core read/write flag, 1 = read, 0 = write |
| halt_req | input | 1 | Bus request from the external master |
| rdy_mode | input | 1 | 0 = ready stalls reads only, 1 = ready stalls reads and writes |
| rdy | output | 1 | Internal ready to the core |
| stall | output | 1 | The core's current cycle is held |
| be | output | 1 | Bus enable for the core's drivers |
| grant | output | 1 | The bus belongs to the external master |
| addr_oe | output | ADDR_W | Per-bit output enables for the core's address drivers |
| data_oe | output | DATA_W | Per-bit output enables for the core's data drivers |
| rw_oe | output | 1 | Output enable for the core's read/write driver |

## Verification
A scoreboard predicts the outputs for each PHI2 half-phase and compares them with the design. The halt sequence runs in the read-only stall mode with a string of write cycles arriving while ready is low. This shows whether the write really passes and the bus release is postponed. The same sequence then runs in the read-and-write stall mode, where a write is held and the release happens at the first falling edge. Two more runs cover a request withdrawn before bus enable ever drops, and a long release and return. Together these separate the edge on which each line moves, and they show that bus enable and ready never change in the same phase.

// File: rtl/bus_rel_pkg.sv
package bus_rel_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STALL  = 2'd1,
    ST_HALT   = 2'd2,
    ST_BEBACK = 2'd3
  } brs_state_t;
endpackage

// File: rtl/phi2_edge_det.sv
module phi2_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phi2,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int W = SYNC_STAGES + 1;

  logic [W-1:0] shreg_q;
  logic [W-1:0] shreg_d;

  always_comb begin
    shreg_d = {shreg_q[W-2:0], phi2};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  // newest synchronised sample against the one before it
  assign rise_evt = shreg_q[W-2] & ~shreg_q[W-1];
  assign fall_evt = ~shreg_q[W-2] & shreg_q[W-1];

  a_r10_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));
endmodule

// File: rtl/rdy_stall_gate.sv
module rdy_stall_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy,
  input  logic cpu_rw,
  input  logic rdy_mode,
  output logic stall
);
  logic hold_write;

  // the read-and-write mode also holds write cycles
  assign hold_write = rdy_mode;
  assign stall      = ~rdy & (cpu_rw | hold_write);

  a_r3_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_mode && !cpu_rw) |-> !stall);
  a_r4_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_mode && !rdy) |-> stall);
endmodule

// File: rtl/bus_rel_fsm.sv
module bus_rel_fsm
  import bus_rel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic fall_evt,
  input  logic halt_req,
  input  logic paused,
  output logic rdy,
  output logic be,
  output logic grant
);
  brs_state_t st_q, st_d;
  logic rdy_q, rdy_d;
  logic be_q, be_d;
  logic grant_q, grant_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:    if (rise_evt && halt_req)            st_d = ST_STALL;
      ST_STALL: begin
        if (fall_evt && halt_req && paused)           st_d = ST_HALT;
        else if (rise_evt && !halt_req)               st_d = ST_RUN;
      end
      ST_HALT:   if (fall_evt && !halt_req)           st_d = ST_BEBACK;
      ST_BEBACK: if (rise_evt)                        st_d = ST_RUN;
      default:                                        st_d = ST_RUN;
    endcase
    rdy_d   = (st_d == ST_RUN);
    be_d    = (st_d != ST_HALT);
    grant_d = (st_d == ST_HALT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      rdy_q   <= 1'b1;
      be_q    <= 1'b1;
      grant_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rdy_q   <= rdy_d;
      be_q    <= be_d;
      grant_q <= grant_d;
    end
  end

  assign rdy   = rdy_q;
  assign be    = be_q;
  assign grant = grant_q;

  a_r2_rdy_falls_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_q) |-> $past(rise_evt));
  a_r5_be_falls_when_paused: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(be_q) |-> ($past(fall_evt) && !$past(rdy_q) && $past(paused)));
  a_r6_grant_only_be_low: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q |-> !be_q);
  a_r7_be_before_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> (be_q && $past(be_q) && $past(rise_evt)));
  a_r7_be_back_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(be_q) |-> $past(fall_evt));
  a_r10_change_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rdy_q) || !$stable(be_q)) |-> $past(rise_evt || fall_evt));
endmodule

// File: rtl/bus_release_seq.sv
module bus_release_seq #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              cpu_rw,
  input  logic              halt_req,
  input  logic              rdy_mode,
  output logic              rdy,
  output logic              stall,
  output logic              be,
  output logic              grant,
  output logic [ADDR_W-1:0] addr_oe,
  output logic [DATA_W-1:0] data_oe,
  output logic              rw_oe
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       rise_evt, fall_evt;

  // asserted asynchronously, released on clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  phi2_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .phi2     (phi2),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  rdy_stall_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rdy      (rdy),
    .cpu_rw   (cpu_rw),
    .rdy_mode (rdy_mode),
    .stall    (stall)
  );

  bus_rel_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .halt_req (halt_req),
    .paused   (stall),
    .rdy      (rdy),
    .be       (be),
    .grant    (grant)
  );

  for (genvar i = 0; i < ADDR_W; i++) begin : g_addr_oe
    assign addr_oe[i] = be;
  end
  for (genvar j = 0; j < DATA_W; j++) begin : g_data_oe
    assign data_oe[j] = be;
  end
  assign rw_oe = be;
endmodule

// File: tb/bus_release_seq_tb.sv
module bus_release_seq_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phi2 = 1'b0;
  logic cpu_rw = 1'b1;
  logic halt_req = 1'b0;
  logic rdy_mode = 1'b0;
  logic rdy, stall, be, grant, rw_oe;
  logic [ADDR_W-1:0] addr_oe;
  logic [DATA_W-1:0] data_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  rdy;
    logic  be;
    logic  grant;
    logic  stall;
    string tag;
  } exp_t;
  exp_t sb_q[$];
  event sample_ev;

  // phase-level model: 0 run, 1 ready low, 2 released, 3 enable back
  int mst = 0;

  always #2 clk = ~clk;

  bus_release_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_rw(cpu_rw),
    .halt_req(halt_req), .rdy_mode(rdy_mode), .rdy(rdy), .stall(stall),
    .be(be), .grant(grant), .addr_oe(addr_oe), .data_oe(data_oe), .rw_oe(rw_oe)
  );

  task automatic chk(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: one PHI2 half-phase, expected outputs pushed to the scoreboard
  task automatic hp(input logic ph, input logic hreq, input logic rw, input string tag);
    exp_t e;
    logic r;
    phi2 = ph; halt_req = hreq; cpu_rw = rw;
    if (ph) begin
      if (mst == 0 && hreq) mst = 1;
      else if (mst == 1 && !hreq) mst = 0;
      else if (mst == 3) mst = 0;
    end else begin
      if (mst == 1 && hreq && (rdy_mode || rw)) mst = 2;
      else if (mst == 2 && !hreq) mst = 3;
    end
    r = (mst == 0);
    e.rdy = r; e.be = (mst != 2); e.grant = (mst == 2);
    e.stall = !r && (rdy_mode || rw);
    e.tag = tag;
    sb_q.push_back(e);
    repeat (HALF - 1) @(posedge clk);
    -> sample_ev;
    @(posedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(sample_ev);
      @(negedge clk);
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rdy, e.rdy, {e.tag, " R2 rdy"});
        chk(be, e.be, {e.tag, " R5 be"});
        chk(grant, e.grant, {e.tag, " R6 grant"});
        chk(stall, e.stall, {e.tag, rdy_mode ? " R4 stall" : " R3 stall"});
        chk(addr_oe == {ADDR_W{e.be}} && data_oe == {DATA_W{e.be}} && rw_oe == e.be,
            1'b1, {e.tag, " R9 oe"});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(rdy, 1'b1, "R1 rdy");
    chk(be, 1'b1, "R1 be");
    chk(grant, 1'b0, "R1 grant");
    chk(&addr_oe & &data_oe & rw_oe, 1'b1, "R1 oe");
    @(posedge clk);

    // read-only stall mode, writes during the stall defer the release
    rdy_mode = 1'b0;
    hp(1, 0, 1, "R10 idle"); hp(0, 0, 1, "R10 idle");
    hp(1, 1, 1, "R2 halt");
    hp(0, 1, 0, "R3 write passes");
    hp(1, 1, 0, "R3 write passes");
    hp(0, 1, 1, "R5 release on read");
    hp(1, 1, 1, "R6 held");
    hp(0, 0, 1, "R7 be back");
    hp(1, 0, 1, "R7 rdy back");

    // read-and-write stall mode, write is held at once
    rdy_mode = 1'b1;
    hp(0, 0, 1, "R10 idle");
    hp(1, 1, 0, "R2 halt");
    hp(0, 1, 0, "R4 write held");
    hp(1, 1, 0, "R6 held");
    hp(0, 0, 0, "R7 be back");
    hp(1, 0, 0, "R7 rdy back");

    // request withdrawn before bus enable drops
    hp(0, 0, 1, "R10 idle");
    hp(1, 1, 1, "R2 halt");
    hp(0, 0, 1, "R8 withdrawn");
    hp(1, 0, 1, "R8 rdy back");

    // long write run in read-only stall mode
    rdy_mode = 1'b0;
    hp(0, 0, 1, "R10 idle");
    hp(1, 1, 0, "R2 halt");
    hp(0, 1, 0, "R5 deferred");
    hp(1, 1, 0, "R5 deferred");
    hp(0, 1, 0, "R5 deferred");
    hp(1, 1, 1, "R5 deferred");
    hp(0, 1, 1, "R5 release");
    hp(1, 1, 1, "R6 held");
    hp(0, 1, 0, "R6 held");
    hp(1, 1, 0, "R6 held");
    hp(0, 0, 1, "R7 be back");
    hp(1, 0, 1, "R7 rdy back");
    hp(0, 0, 1, "R10 idle");

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule